// File: doc/BRIEF.md
# Indirect Addressing Pointer Unit

This block keeps three 12-bit data-memory pointers and resolves register-file accesses into data-memory addresses. Each pointer is visible at two byte registers, a 4-bit high part and an 8-bit low part, and at five virtual registers. The address of a virtual register picks both the pointer and the access mode. Touching a virtual register does not reach any storage under its own address. The access is steered to the location the pointer names, and the pointer may be adjusted as a side effect.

The access modes are plain, post-increment, post-decrement, pre-increment and offset-by-working-register. In the offset mode the 8-bit working register is sign-extended and added to the pointer. The pointer itself does not change in that mode.

Each cycle the unit presents an effective address. For a virtual-register access this is the resolved address. For any other address it is the register address itself. A flag marks resolved accesses. A read of a pointer byte register returns the byte. The data memory and the arithmetic unit sit outside this block.

Top module: `indaddr_unit`

## Requirements
- R1: Synchronous active-high reset clears all three pointers to 0x000, so every pointer byte register reads back 0x00.
- R2: The address map is fixed. For pointer k (k = 0, 1, 2), let B = 0xFEF - 8k. The plain register is at B, post-increment at B-1, post-decrement at B-2, pre-increment at B-3, offset-by-W at B-4, the high byte at B-5 and the low byte at B-6. The indirect flag is 1 exactly when a read or write strobe is active and the address is one of the five virtual registers. Otherwise the effective address equals the register address.
- R3: A plain access gives the pointer value as the effective address and leaves the pointer unchanged.
- R4: A post-increment access gives the current pointer value as the effective address. After that clock edge the pointer is one higher.
- R5: A post-decrement access gives the current pointer value as the effective address. After that clock edge the pointer is one lower.
- R6: A pre-increment access gives the pointer plus one as the effective address. After that clock edge the pointer holds that same value.
- R7: An offset-by-W access gives the pointer plus the sign-extended 8-bit working register as the effective address, and leaves the pointer unchanged.
- R8: All pointer and address arithmetic wraps modulo 4096. For example, 0xFFF + 1 = 0x000 and 0x080 - 128 = 0x000.
- R9: A write to the high byte loads bits 3:0 of the write data into pointer bits 11:8. A write to the low byte loads the full byte into bits 7:0. The new value is in effect from the next cycle. A high-byte read returns 0 in bits 7:4. Reads of addresses that are not pointer byte registers return 0x00.
- R10: The three pointers are independent. An access to one pointer's registers never changes another pointer.
- R11: With both strobes low, no pointer changes and the indirect flag is 0, even when the address is a virtual register.
- R12: A write strobe on a virtual register has the same address resolution and pointer side effect as a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 12 | Register-file address of the current access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| wreg | input | 8 | Current working-register value |
| eff_addr | output | 12 | Effective data-memory address |
| is_indirect | output | 1 | High when the access resolved through a pointer |
| rd_data | output | 8 | Read-back value of a pointer byte register |

## Verification
A single pointer is walked through every access mode in turn. This shows whether each mode takes its address before or after the pointer update. It also shows whether the update goes in the right direction, or happens at all for the plain and offset modes.

The offset mode is tried with small positive, negative, most-negative and most-positive working-register values. These separate a sign-extended addition from an unsigned one.

A pointer is parked at 0xFFF and then at 0x000, which exposes missing wraparound in both directions. Interleaving accesses to the other two pointers shows whether any decode overlaps between pointers.

Idle cycles on a virtual-register address, write strobes on a virtual register, and reads of the high byte after it was written with ones in its upper nibble each single out a further rule.

// File: rtl/indaddr_pkg.sv
package indaddr_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 8;
    localparam int NUM_PTR  = 3;
    localparam int IDX_W    = 2;
    localparam int HI_W     = ADDR_W - DATA_W;
    localparam logic [ADDR_W-1:0] TOP_BASE   = 12'hFEF;
    localparam int                BASE_STEP  = 8;
    localparam int                SLOTS      = 7;

    typedef enum logic [2:0] {
        ACC_NONE    = 3'd0,
        ACC_PLAIN   = 3'd1,
        ACC_POSTINC = 3'd2,
        ACC_POSTDEC = 3'd3,
        ACC_PREINC  = 3'd4,
        ACC_PLUSW   = 3'd5,
        ACC_BYTE_HI = 3'd6,
        ACC_BYTE_LO = 3'd7
    } acc_kind_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        acc_kind_e        kind;
    } decode_t;

    function automatic logic [ADDR_W-1:0] ptr_base(input int k);
        return ADDR_W'(TOP_BASE - ADDR_W'(BASE_STEP * k));
    endfunction

    function automatic acc_kind_e slot_kind(input logic [2:0] off);
        case (off)
            3'd0:    return ACC_PLAIN;
            3'd1:    return ACC_POSTINC;
            3'd2:    return ACC_POSTDEC;
            3'd3:    return ACC_PREINC;
            3'd4:    return ACC_PLUSW;
            3'd5:    return ACC_BYTE_HI;
            3'd6:    return ACC_BYTE_LO;
            default: return ACC_NONE;
        endcase
    endfunction

    function automatic logic is_virtual(input acc_kind_e k);
        return (k == ACC_PLAIN) || (k == ACC_POSTINC) || (k == ACC_POSTDEC) ||
               (k == ACC_PREINC) || (k == ACC_PLUSW);
    endfunction

    function automatic logic [ADDR_W-1:0] sext_w(input logic [DATA_W-1:0] w);
        return {{(ADDR_W-DATA_W){w[DATA_W-1]}}, w};
    endfunction

endpackage

// File: rtl/indaddr_decode.sv
module indaddr_decode
    import indaddr_pkg::*;
(
    input  logic [ADDR_W-1:0] reg_addr,
    output decode_t           dec
);

    logic [NUM_PTR-1:0] hit_v;
    logic [2:0]         off_v [NUM_PTR];

    for (genvar k = 0; k < NUM_PTR; k++) begin : g_slot
        logic [ADDR_W-1:0] diff;
        assign diff     = ptr_base(k) - reg_addr;
        assign hit_v[k] = (diff < ADDR_W'(SLOTS));
        assign off_v[k] = diff[2:0];
    end

    always_comb begin
        dec.hit  = 1'b0;
        dec.idx  = '0;
        dec.kind = ACC_NONE;
        for (int k = 0; k < NUM_PTR; k++) begin
            if (hit_v[k]) begin
                dec.hit  = 1'b1;
                dec.idx  = IDX_W'(k);
                dec.kind = slot_kind(off_v[k]);
            end
        end
    end

endmodule

// File: rtl/indaddr_ptr.sv
module indaddr_ptr
    import indaddr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              access,
    input  logic              wr_en,
    input  acc_kind_e         kind,
    input  logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] q
);

    logic [ADDR_W-1:0] nxt;

    always_comb begin
        nxt = q;
        if (sel && access) begin
            unique case (kind)
                ACC_POSTINC, ACC_PREINC: nxt = q + ADDR_W'(1);
                ACC_POSTDEC:             nxt = q - ADDR_W'(1);
                ACC_BYTE_HI: if (wr_en) nxt = {wr_data[HI_W-1:0], q[DATA_W-1:0]};
                ACC_BYTE_LO: if (wr_en) nxt = {q[ADDR_W-1:DATA_W], wr_data};
                default:                 nxt = q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

endmodule

// File: rtl/indaddr_agen.sv
module indaddr_agen
    import indaddr_pkg::*;
(
    input  decode_t           dec,
    input  logic              access,
    input  logic [ADDR_W-1:0] ptr_sel,
    input  logic [DATA_W-1:0] wreg,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              is_indirect
);

    always_comb begin
        is_indirect = access && dec.hit && is_virtual(dec.kind);
        eff_addr    = reg_addr;
        if (is_indirect) begin
            unique case (dec.kind)
                ACC_PREINC: eff_addr = ptr_sel + ADDR_W'(1);
                ACC_PLUSW:  eff_addr = ptr_sel + sext_w(wreg);
                default:    eff_addr = ptr_sel;
            endcase
        end
    end

endmodule

// File: rtl/indaddr_unit.sv
module indaddr_unit
    import indaddr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [11:0] reg_addr,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic [7:0]  wreg,
    output logic [11:0] eff_addr,
    output logic        is_indirect,
    output logic [7:0]  rd_data
);

    decode_t                      dec;
    logic                         access;
    logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0]            ptr_sel;

    assign access = rd_en | wr_en;

    indaddr_decode u_dec (
        .reg_addr (reg_addr),
        .dec      (dec)
    );

    for (genvar k = 0; k < NUM_PTR; k++) begin : g_ptr
        indaddr_ptr u_ptr (
            .clk     (clk),
            .rst     (rst),
            .sel     (dec.hit && (dec.idx == IDX_W'(k))),
            .access  (access),
            .wr_en   (wr_en),
            .kind    (dec.kind),
            .wr_data (wr_data),
            .q       (ptr_q[k])
        );
    end

    always_comb begin
        ptr_sel = '0;
        for (int k = 0; k < NUM_PTR; k++)
            if (dec.idx == IDX_W'(k)) ptr_sel = ptr_q[k];
    end

    indaddr_agen u_agen (
        .dec         (dec),
        .access      (access),
        .ptr_sel     (ptr_sel),
        .wreg        (wreg),
        .reg_addr    (reg_addr),
        .eff_addr    (eff_addr),
        .is_indirect (is_indirect)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en && dec.hit) begin
            if (dec.kind == ACC_BYTE_HI)
                rd_data = {{(DATA_W-HI_W){1'b0}}, ptr_sel[ADDR_W-1:DATA_W]};
            else if (dec.kind == ACC_BYTE_LO)
                rd_data = ptr_sel[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/indaddr_unit_chk.sv
module indaddr_unit_chk (
    input logic              clk,
    input logic              rst,
    input logic [11:0]       reg_addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [7:0]        wreg,
    input logic [11:0]       eff_addr,
    input logic              is_indirect,
    input logic [7:0]        rd_data,
    input logic [2:0][11:0]  ptr_q
);

    logic acc;
    assign acc = rd_en | wr_en;

    p_idle_flat_r11: assert property (@(posedge clk) disable iff (rst)
        !acc |-> (!is_indirect && eff_addr == reg_addr));

    p_idle_keep_r11: assert property (@(posedge clk) disable iff (rst)
        !acc |=> $stable(ptr_q));

    p_postinc_step_r4: assert property (@(posedge clk) disable iff (rst)
        (acc && reg_addr == 12'hFEE) |=> ptr_q[0] == 12'($past(ptr_q[0]) + 12'd1));

    p_postdec_step_r5: assert property (@(posedge clk) disable iff (rst)
        (acc && reg_addr == 12'hFE5) |=> ptr_q[1] == 12'($past(ptr_q[1]) - 12'd1));

    p_preinc_addr_r6: assert property (@(posedge clk) disable iff (rst)
        (acc && reg_addr == 12'hFDC) |-> eff_addr == 12'(ptr_q[2] + 12'd1));

    p_plusw_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (acc && reg_addr == 12'hFEB) |=> $stable(ptr_q[0]));

    p_hi_nibble_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (reg_addr == 12'hFEA || reg_addr == 12'hFE2 || reg_addr == 12'hFDA))
        |-> rd_data[7:4] == 4'h0);

    p_plain_addr_r3: assert property (@(posedge clk) disable iff (rst)
        (acc && reg_addr == 12'hFE7) |-> (is_indirect && eff_addr == ptr_q[1]));

endmodule

bind indaddr_unit indaddr_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_addr    (reg_addr),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .wreg        (wreg),
    .eff_addr    (eff_addr),
    .is_indirect (is_indirect),
    .rd_data     (rd_data),
    .ptr_q       (ptr_q)
);

// File: tb/indaddr_unit_bench.sv
module indaddr_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] reg_addr;
    logic        rd_en, wr_en;
    logic [7:0]  wr_data, wreg;
    logic [11:0] eff_addr;
    logic        is_indirect;
    logic [7:0]  rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    indaddr_unit u_indaddr_unit (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .wreg(wreg), .eff_addr(eff_addr),
        .is_indirect(is_indirect), .rd_data(rd_data)
    );

    typedef struct packed {
        logic [7:0]  rq;
        logic [11:0] a;
        logic        rd;
        logic        wr;
        logic [7:0]  d;
        logic [7:0]  w;
        logic [11:0] e;
        logic        ind;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{8'd9,  12'hFEA, 1'b0, 1'b1, 8'hF3, 8'h00, 12'hFEA, 1'b0}, // R9 hi write
        '{8'd9,  12'hFE9, 1'b0, 1'b1, 8'h10, 8'h00, 12'hFE9, 1'b0}, // R9 lo write -> 0x310
        '{8'd3,  12'hFEF, 1'b1, 1'b0, 8'h00, 8'h00, 12'h310, 1'b1}, // R3 plain
        '{8'd4,  12'hFEE, 1'b1, 1'b0, 8'h00, 8'h00, 12'h310, 1'b1}, // R4 -> 311
        '{8'd4,  12'hFEE, 1'b1, 1'b0, 8'h00, 8'h00, 12'h311, 1'b1}, // R4 -> 312
        '{8'd5,  12'hFED, 1'b1, 1'b0, 8'h00, 8'h00, 12'h312, 1'b1}, // R5 -> 311
        '{8'd6,  12'hFEC, 1'b1, 1'b0, 8'h00, 8'h00, 12'h312, 1'b1}, // R6 -> 312
        '{8'd7,  12'hFEB, 1'b1, 1'b0, 8'h00, 8'h05, 12'h317, 1'b1}, // R7 +5
        '{8'd7,  12'hFEB, 1'b1, 1'b0, 8'h00, 8'hFE, 12'h310, 1'b1}, // R7 -2
        '{8'd3,  12'hFEF, 1'b1, 1'b0, 8'h00, 8'h00, 12'h312, 1'b1}, // R3 after plus-W
        '{8'd9,  12'hFE2, 1'b0, 1'b1, 8'h0F, 8'h00, 12'hFE2, 1'b0}, // R9 p1 hi
        '{8'd9,  12'hFE1, 1'b0, 1'b1, 8'hFF, 8'h00, 12'hFE1, 1'b0}, // R9 p1 = FFF
        '{8'd8,  12'hFE6, 1'b1, 1'b0, 8'h00, 8'h00, 12'hFFF, 1'b1}, // R8 -> 000
        '{8'd8,  12'hFE7, 1'b1, 1'b0, 8'h00, 8'h00, 12'h000, 1'b1}, // R8 wrapped up
        '{8'd8,  12'hFE5, 1'b1, 1'b0, 8'h00, 8'h00, 12'h000, 1'b1}, // R8 -> FFF
        '{8'd8,  12'hFE4, 1'b1, 1'b0, 8'h00, 8'h00, 12'h000, 1'b1}, // R8 preinc wraps
        '{8'd9,  12'hFDA, 1'b0, 1'b1, 8'h00, 8'h00, 12'hFDA, 1'b0}, // R9 p2 hi
        '{8'd9,  12'hFD9, 1'b0, 1'b1, 8'h80, 8'h00, 12'hFD9, 1'b0}, // R9 p2 = 080
        '{8'd8,  12'hFDB, 1'b1, 1'b0, 8'h00, 8'h80, 12'h000, 1'b1}, // R8 080-128
        '{8'd7,  12'hFDB, 1'b1, 1'b0, 8'h00, 8'h7F, 12'h0FF, 1'b1}, // R7 +127
        '{8'd12, 12'hFDE, 1'b0, 1'b1, 8'h55, 8'h00, 12'h080, 1'b1}, // R12 write postinc -> 081
        '{8'd12, 12'hFDF, 1'b1, 1'b0, 8'h00, 8'h00, 12'h081, 1'b1}, // R12 side effect seen
        '{8'd10, 12'hFEF, 1'b1, 1'b0, 8'h00, 8'h00, 12'h312, 1'b1}  // R10 p0 untouched
    };

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic [11:0] a, input logic r, input logic w,
                         input logic [7:0] d, input logic [7:0] wv);
        @(negedge clk);
        reg_addr = a; rd_en = r; wr_en = w; wr_data = d; wreg = wv;
        #2;
    endtask

    initial begin
        rst = 1'b1; reg_addr = '0; rd_en = 0; wr_en = 0; wr_data = '0; wreg = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every byte register
        drive(12'hFEA, 1, 0, 0, 0); chk("R1", "p0 hi", rd_data, 0);
        drive(12'hFE9, 1, 0, 0, 0); chk("R1", "p0 lo", rd_data, 0);
        drive(12'hFE1, 1, 0, 0, 0); chk("R1", "p1 lo", rd_data, 0);
        drive(12'hFD9, 1, 0, 0, 0); chk("R1", "p2 lo", rd_data, 0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            drive(VEC[i].a, VEC[i].rd, VEC[i].wr, VEC[i].d, VEC[i].w);
            tag = $sformatf("R%0d", VEC[i].rq);
            chk(tag, $sformatf("vec%0d eff", i), eff_addr, VEC[i].e);
            chk("R2", $sformatf("vec%0d flag", i), is_indirect, VEC[i].ind);
        end

        // R9: readback, upper nibble of the high byte is zero
        drive(12'hFEA, 1, 0, 0, 0); chk("R9", "p0 hi readback", rd_data, 8'h03);
        drive(12'hFE9, 1, 0, 0, 0); chk("R9", "p0 lo readback", rd_data, 8'h12);
        drive(12'hFE2, 1, 0, 0, 0); chk("R9", "p1 hi readback", rd_data, 8'h00);
        drive(12'hFD9, 1, 0, 0, 0); chk("R9", "p2 lo readback", rd_data, 8'h81);
        drive(12'h123, 1, 0, 0, 0); chk("R9", "non-pointer read", rd_data, 8'h00);
        chk("R2", "direct eff", eff_addr, 12'h123);
        chk("R2", "direct flag", is_indirect, 0);

        // R11: idle cycles on a virtual register change nothing
        drive(12'hFEE, 0, 0, 0, 0); chk("R11", "idle flag", is_indirect, 0);
        chk("R11", "idle eff", eff_addr, 12'hFEE);
        drive(12'hFED, 0, 0, 0, 0);
        drive(12'hFE9, 1, 0, 0, 0); chk("R11", "p0 lo after idle", rd_data, 8'h12);

        // R10: pointer 2 write leaves pointer 1 alone
        drive(12'hFD9, 0, 1, 8'h44, 0);
        drive(12'hFE1, 1, 0, 0, 0); chk("R10", "p1 lo", rd_data, 8'h00);
        drive(12'hFD9, 1, 0, 0, 0); chk("R9", "p2 lo new", rd_data, 8'h44);

        // R1: mid-run reset clears pointers
        @(negedge clk); rst = 1'b1; rd_en = 0; wr_en = 0;
        @(negedge clk); rst = 1'b0;
        drive(12'hFE9, 1, 0, 0, 0); chk("R1", "p0 lo after reset", rd_data, 0);
        drive(12'hFEF, 1, 0, 0, 0); chk("R1", "p0 eff after reset", eff_addr, 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule